// File: doc/BRIEF.md
# Audio Sample-Rate Strobe Generator

This block derives periodic single-cycle sample strobes from one core clock. It produces a base-rate strobe and three consumer strobes: one for the data converters, one for the processing core and one for the serial port. A control word sets three things. It selects whether the core clock comes from the master clock or from a frequency synthesiser. It sets how many core cycles make up one base sample period. It holds the core enable. Each consumer also has its own rate code, which picks a multiple or a fraction of the base rate.

The block works internally on a half-base-period tick. Every divisor (0.5, 1, 1.5, 2, 3, 4, 6) is therefore a whole number of half periods, and all four strobes come from a single prescaler. Any write that changes a field restarts every strobe phase together. As a result, strobes with equal periods always fall on the same cycle, and a new configuration never produces a short or doubled period. There is no data stream here; every pin is a plain control or status pin.

Top module: `sample_strobe_gen`

## Requirements
- R1: After reset the control readback is 4'b0000 and no strobe is asserted.
- R2: A write with `reg_sel`=0 loads the control word: bit 0 is the core enable, bits [2:1] are the ratio code, and bit 3 is the source flag (0 = master clock, 1 = synthesiser). `ctl_readback` returns the stored word in the same bit positions.
- R3: When a control write sets bit 3, the stored ratio code becomes 2'b11 whatever was written, and the readback shows 2'b11. A later write with bit 3 clear stores the written ratio code again.
- R4: While the enable bit is 0, no strobe is asserted. After an enabling write, each strobe first fires exactly one full period later.
- R5: The base strobe period is UNIT×(ratio code+1) core cycles. With the default UNIT=256 this is 256, 512, 768 or 1024 cycles.
- R6: Rate codes are written with `reg_sel` 1 (converters), 2 (core) and 3 (serial port), using data bits [2:0]. Codes 0..6 select the divisors 0.5, 1, 1.5, 2, 3, 4 and 6. A consumer's period is the base period times its divisor.
- R7: Rate code 7 behaves exactly like code 1 (the base rate).
- R8: Every strobe is high for exactly one core cycle per period.
- R9: A write that changes any field restarts all strobes. No strobe is asserted until its full new period has elapsed, counted from the write edge, and each strobe then fires on the last cycle of each period.
- R10: Strobes that have the same period are asserted on the same cycles. This includes a consumer at the base rate and the base strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 converter rate, 2 core rate, 3 serial rate |
| reg_wdata | input | 4 | Write data |
| ctl_readback | output | 4 | Stored control word {source, ratio[1:0], enable} |
| base_stb | output | 1 | Base-rate strobe |
| conv_stb | output | 1 | Converter strobe |
| proc_stb | output | 1 | Processing-core strobe |
| ser_stb | output | 1 | Serial-port strobe |

## Verification
The hardest situation to reach is a configuration change in the middle of a period, when some strobes are part-way through a fractional-divisor period. The new period must start cleanly, with no leftover or doubled strobe. The bench builds the block with a small UNIT so that even the longest periods last only a few hundred cycles. It sweeps every ratio code, with both source settings, against every rate code. It then writes a new rate at an odd offset into a running period, and it sets and clears the source flag, checking the schedule of every strobe cycle by cycle from that write edge.

// File: rtl/sstb_pkg.sv
`timescale 1ns/1ps
package sstb_pkg;
  localparam int N_CONS     = 3;
  localparam int MULT_W     = 4;
  localparam int BASE_HALVES = 2;

  typedef logic [1:0] ratio_code_t;
  typedef logic [2:0] rate_code_t;

  typedef enum logic [1:0] {
    SEL_CTL  = 2'd0,
    SEL_CONV = 2'd1,
    SEL_PROC = 2'd2,
    SEL_SER  = 2'd3
  } reg_sel_e;

  // Period of a consumer expressed in half base periods.
  function automatic logic [MULT_W-1:0] half_mult(input rate_code_t code);
    case (code)
      3'd0:    half_mult = 4'd1;
      3'd1:    half_mult = 4'd2;
      3'd2:    half_mult = 4'd3;
      3'd3:    half_mult = 4'd4;
      3'd4:    half_mult = 4'd6;
      3'd5:    half_mult = 4'd8;
      3'd6:    half_mult = 4'd12;
      default: half_mult = 4'd2;
    endcase
  endfunction
endpackage

// File: rtl/ssg_ctl_regs.sv
`timescale 1ns/1ps
module ssg_ctl_regs
  import sstb_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_we,
  input  logic [1:0]               reg_sel,
  input  logic [3:0]               reg_wdata,
  output logic                     src_q,
  output ratio_code_t              ratio_q,
  output logic                     en_q,
  output logic [N_CONS-1:0][2:0]   rate_q,
  output logic                     restart
);
  logic [3:0] new_ctl;
  logic       changed;

  // Selecting the synthesiser forces the ratio field to the top code.
  always_comb begin
    new_ctl = {reg_wdata[3], (reg_wdata[3] ? 2'b11 : reg_wdata[2:1]), reg_wdata[0]};
    if (reg_sel == SEL_CTL)
      changed = (new_ctl != {src_q, ratio_q, en_q});
    else
      changed = (reg_wdata[2:0] != rate_q[reg_sel - 2'd1]);
    restart = reg_we && changed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= 1'b0;
      ratio_q <= 2'b00;
      en_q    <= 1'b0;
      rate_q  <= '0;
    end else if (reg_we) begin
      if (reg_sel == SEL_CTL) begin
        src_q   <= new_ctl[3];
        ratio_q <= new_ctl[2:1];
        en_q    <= new_ctl[0];
      end else begin
        rate_q[reg_sel - 2'd1] <= reg_wdata[2:0];
      end
    end
  end
endmodule

// File: rtl/ssg_half_timer.sv
`timescale 1ns/1ps
module ssg_half_timer
  import sstb_pkg::*;
#(
  parameter int UNIT = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        clear,
  input  ratio_code_t ratio,
  output logic        tick
);
  localparam int HALF_UNIT = UNIT / 2;
  localparam int HC_W      = $clog2(HALF_UNIT * 4);

  logic [HC_W:0]   prod;
  logic [HC_W-1:0] limit;
  logic [HC_W-1:0] hcnt;

  // Half base period = HALF_UNIT * (ratio code + 1) core cycles.
  always_comb begin
    prod  = (HC_W+1)'(HALF_UNIT) * (HC_W+1)'({1'b0, ratio} + 3'd1);
    limit = HC_W'(prod - (HC_W+1)'(1));
  end

  assign tick = run && (hcnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hcnt <= '0;
    else if (clear || !run)
      hcnt <= '0;
    else if (tick)
      hcnt <= '0;
    else
      hcnt <= hcnt + 1'b1;
  end
endmodule

// File: rtl/ssg_rate_div.sv
`timescale 1ns/1ps
module ssg_rate_div
  import sstb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clear,
  input  logic              tick,
  input  logic [MULT_W-1:0] mult,
  output logic              stb
);
  logic [MULT_W-1:0] scnt;
  logic [MULT_W-1:0] last;

  assign last = MULT_W'(mult - 4'd1);
  assign stb  = run && tick && (scnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      scnt <= '0;
    else if (clear || !run)
      scnt <= '0;
    else if (tick)
      scnt <= (scnt == last) ? '0 : scnt + 1'b1;
  end
endmodule

// File: rtl/sample_strobe_gen.sv
`timescale 1ns/1ps
module sample_strobe_gen
  import sstb_pkg::*;
#(
  parameter int UNIT = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [1:0] reg_sel,
  input  logic [3:0] reg_wdata,
  output logic [3:0] ctl_readback,
  output logic       base_stb,
  output logic       conv_stb,
  output logic       proc_stb,
  output logic       ser_stb
);
  localparam int N_CH = N_CONS + 1;

  logic                   src_q;
  logic                   en_q;
  logic                   restart;
  logic                   half_tick;
  ratio_code_t            ratio_q;
  logic [N_CONS-1:0][2:0] rate_q;
  logic [N_CH-1:0][MULT_W-1:0] mult;
  logic [N_CH-1:0]        stb;

  ssg_ctl_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .src_q     (src_q),
    .ratio_q   (ratio_q),
    .en_q      (en_q),
    .rate_q    (rate_q),
    .restart   (restart)
  );

  ssg_half_timer #(.UNIT(UNIT)) u_half (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (en_q),
    .clear (restart),
    .ratio (ratio_q),
    .tick  (half_tick)
  );

  // Channel 0 is the base rate; channels 1..N_CONS are the consumers.
  assign mult[0] = MULT_W'(BASE_HALVES);

  generate
    for (genvar i = 0; i < N_CONS; i++) begin : g_mult
      assign mult[i+1] = half_mult(rate_q[i]);
    end
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      ssg_rate_div u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (en_q),
        .clear (restart),
        .tick  (half_tick),
        .mult  (mult[c]),
        .stb   (stb[c])
      );
    end
  endgenerate

  assign ctl_readback = {src_q, ratio_q, en_q};
  assign base_stb     = stb[0];
  assign conv_stb     = stb[1];
  assign proc_stb     = stb[2];
  assign ser_stb      = stb[3];
endmodule

// File: rtl/sstb_checker.sv
`timescale 1ns/1ps
module sstb_checker
  import sstb_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [1:0] reg_sel,
  input logic [3:0] reg_wdata,
  input logic [3:0] ctl_readback,
  input logic       base_stb,
  input logic       conv_stb,
  input logic       proc_stb,
  input logic       ser_stb
);
  // Shadow of the written rate codes and control word, tracked from the write port.
  logic [3:0]             sh_ctl;
  logic [N_CONS-1:0][2:0] sh_rate;
  logic [3:0]             nxt_ctl;
  logic                   sh_chg;
  logic                   any_stb;

  always_comb begin
    nxt_ctl = {reg_wdata[3], (reg_wdata[3] ? 2'b11 : reg_wdata[2:1]), reg_wdata[0]};
    if (reg_sel == SEL_CTL)
      sh_chg = reg_we && (nxt_ctl != sh_ctl);
    else
      sh_chg = reg_we && (reg_wdata[2:0] != sh_rate[reg_sel - 2'd1]);
    any_stb = base_stb || conv_stb || proc_stb || ser_stb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_ctl  <= '0;
      sh_rate <= '0;
    end else if (reg_we) begin
      if (reg_sel == SEL_CTL) sh_ctl <= nxt_ctl;
      else sh_rate[reg_sel - 2'd1] <= reg_wdata[2:0];
    end
  end

  assert_one_cycle_base_R8: assert property (@(posedge clk) disable iff (!rst_n)
    base_stb |=> !base_stb);
  assert_one_cycle_conv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    conv_stb |=> !conv_stb);
  assert_one_cycle_proc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    proc_stb |=> !proc_stb);
  assert_one_cycle_ser_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ser_stb |=> !ser_stb);

  assert_quiet_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_readback[0] |-> !any_stb);

  assert_forced_ratio_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_readback[3] |-> (ctl_readback[2:1] == 2'b11));

  assert_restart_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sh_chg |=> !any_stb);

  assert_same_period_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (half_mult(sh_rate[0]) == half_mult(sh_rate[1])) |-> (conv_stb == proc_stb));

  assert_base_multiple_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_stb && !half_mult(sh_rate[0])[0]) |-> base_stb);
endmodule

bind sample_strobe_gen sstb_checker u_sstb_chk (.*);

// File: tb/tb_sample_strobe_gen.sv
`timescale 1ns/1ps
module tb_sample_strobe_gen;
  localparam int UNIT = 16;
  localparam int HALF = UNIT / 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [3:0] reg_wdata = 4'd0;
  logic [3:0] ctl_readback;
  logic       base_stb, conv_stb, proc_stb, ser_stb;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sample_strobe_gen #(.UNIT(UNIT)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ctl_readback(ctl_readback), .base_stb(base_stb),
    .conv_stb(conv_stb), .proc_stb(proc_stb), .ser_stb(ser_stb)
  );

  function automatic int mult_of(input int code);
    case (code)
      0: return 1;  1: return 2;  2: return 3;  3: return 4;
      4: return 6;  5: return 8;  6: return 12; default: return 2;
    endcase
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // Caller stands at a negedge; returns at the negedge after the write edge.
  task automatic wr(input logic [1:0] sel, input logic [3:0] d);
    reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // Cycle k=0 is the cycle right after the reference edge; a strobe of period P
  // is expected when (k+1) is a multiple of P. P=0 means never.
  task automatic observe(input int p0, input int p1, input int p2, input int p3,
                         input int n, input string tag);
    int per[4];
    int mis[4];
    int first[4];
    int align_mis;
    string nm[4];
    per = '{p0, p1, p2, p3};
    nm  = '{"base", "conv", "proc", "ser"};
    mis = '{0, 0, 0, 0};
    first = '{-1, -1, -1, -1};
    align_mis = 0;
    for (int k = 0; k < n; k++) begin
      logic [3:0] s;
      s = {ser_stb, proc_stb, conv_stb, base_stb};
      for (int ch = 0; ch < 4; ch++) begin
        logic e;
        e = (per[ch] != 0) && (((k + 1) % per[ch]) == 0);
        if (s[ch] !== e) begin
          if (mis[ch] == 0) first[ch] = k;
          mis[ch]++;
        end
      end
      if ((per[1] == per[2]) && (conv_stb !== proc_stb)) align_mis++;
      @(negedge clk);
    end
    for (int ch = 0; ch < 4; ch++)
      chk(mis[ch] == 0, $sformatf("%s %s schedule (first bad cycle %0d) mismatches",
          tag, nm[ch], first[ch]), mis[ch], 0);
    if (per[1] == per[2])
      chk(align_mis == 0, $sformatf("R10 %s conv/proc coincidence mismatches", tag),
          align_mis, 0);
  endtask

  initial begin
    #(190000 * 5);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int h, sc, pmax;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(ctl_readback == 4'b0000, "R1 readback after reset", ctl_readback, 0);
    observe(0, 0, 0, 0, 60, "R1 idle");

    // Sweep: source flag x ratio code x rate code (R2 R3 R5 R6 R7 R8 R9 R10)
    for (int src = 0; src < 2; src++) begin
      for (int r = 0; r < 4; r++) begin
        for (int c = 0; c < 8; c++) begin
          logic [3:0] expr;
          sc = (c + 3) % 8;
          wr(2'd0, {src[0], r[1:0], 1'b0});
          wr(2'd1, {1'b0, c[2:0]});
          wr(2'd2, {1'b0, c[2:0]});
          wr(2'd3, {1'b0, sc[2:0]});
          wr(2'd0, {src[0], r[1:0], 1'b1});
          expr = {src[0], (src != 0) ? 2'b11 : r[1:0], 1'b1};
          chk(ctl_readback == expr,
              (src != 0) ? "R3 forced ratio readback" : "R2 control readback",
              ctl_readback, expr);
          h = (src != 0) ? 4 * HALF : (r + 1) * HALF;
          pmax = h * ((mult_of(c) > mult_of(sc)) ? mult_of(c) : mult_of(sc));
          if (pmax < 2 * h) pmax = 2 * h;
          observe(2 * h, h * mult_of(c), h * mult_of(c), h * mult_of(sc), 2 * pmax + 2,
                  $sformatf("R5 R6 R8 R9 %s src=%0d ratio=%0d code=%0d",
                            (c == 7 || sc == 7) ? "R7" : "", src, r, c));
        end
      end
    end

    // R4: disabled -> silent; re-enable restarts a full period
    wr(2'd0, 4'b0000);
    chk(ctl_readback == 4'b0000, "R4 readback disabled", ctl_readback, 0);
    observe(0, 0, 0, 0, 600, "R4 disabled");
    wr(2'd0, 4'b0001);
    // conv=proc=7 (2 halves), ser=2 (3 halves), half = 8 cycles
    observe(16, 16, 16, 24, 200, "R4 R7 re-enable");

    // R9: change a rate in the middle of a running period
    repeat (37) @(negedge clk);
    wr(2'd1, 4'd5);
    observe(16, 64, 16, 24, 200, "R9 mid-period change");

    // R3: source flag overrides, then clearing it restores the written code
    repeat (11) @(negedge clk);
    wr(2'd0, 4'b1001);
    chk(ctl_readback == 4'b1111, "R3 source set readback", ctl_readback, 4'b1111);
    observe(64, 256, 64, 96, 520, "R3 forced ratio schedule");
    wr(2'd0, 4'b0101);
    chk(ctl_readback == 4'b0101, "R3 source cleared readback", ctl_readback, 4'b0101);
    observe(48, 192, 48, 72, 400, "R3 R5 restored ratio schedule");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule